// File: doc/BRIEF.md
# Memory Integrity Check Sequencer

This block walks a set of memory regions, reads them word by word through a simple bus-master read port and feeds the words to an external hash engine. Each region is called a block. There are up to `NBLK` blocks. Each block is built from up to `NSEG` address/length pieces that may lie anywhere in memory. The pieces of one block are read one after the other and hashed as one message. The hash engine returns one digest per block.

A pass is started with a one-cycle `start`. In one-time mode each digest is kept in an internal per-block store, and the host is told when the pass is over. In continuous mode passes repeat back to back while `cont_mode` stays high. Each new digest is compared with the stored one, and only a difference is reported: an interrupt pulse plus a sticky error line toward a security monitor.

Two timers bound the block's behaviour. A duty-cycle throttle limits how long the sequencer may hold its bus request. A watchdog stops everything if one block takes too long.

Top module: `imc_seq`

## Requirements
- R1: After reset, `rd_req`, `hash_valid`, `hash_last`, `busy`, `done_irq`, `mism_irq`, `sec_err` and `wd_timeout` are all 0.
- R2: Within a pass, enabled blocks are visited in ascending index order and disabled blocks are skipped. Inside a block, piece 0 is read before piece 1. Each piece is read at `base`, `base+DW/8`, ... for `len` words, and every returned word is handed to the hash port unchanged and in order.
- R3: Pieces with length 0 are skipped. An enabled block whose pieces are all of length 0 sends no words and no digest is awaited for it.
- R4: `hash_last` is 1 exactly on the final word of each block's message (the last word of its last non-empty piece), and 0 on every other word.
- R5: In one-time mode (`cont_mode`=1 not sampled at `start`), each digest is written to that block's store. One single-cycle `done_irq` pulse follows the last block of the pass, and no compare is made.
- R6: In continuous mode (`cont_mode`=1 at `start`), digests are compared against the store and never written to it. No `done_irq` is raised. A new pass starts at once after each pass while `cont_mode` is 1, and the block goes idle after the pass in which `cont_mode` is seen at 0.
- R7: A continuous-mode digest that differs from the stored one gives a single-cycle `mism_irq` pulse with `err_blk` set to the block index. It also sets `sec_err`, which stays 1 until reset.
- R8: When both `bus_on` and `bus_off` are nonzero, `rd_req` is never 1 for more than `bus_on` consecutive cycles. When either of them is 0, no throttling is applied.
- R9: The watchdog reloads to `wd_limit` at the start of each block and counts cycles spent reading, feeding or awaiting the digest. If it runs out, `wd_timeout` becomes 1 and stays 1 until reset. From then on `rd_req` and `hash_valid` stay 0, `busy` is 0 and `start` is ignored.
- R10: Only one read is in flight at a time. After a grant (`rd_req` and `rd_gnt` both 1), `rd_req` stays 0 until that word has been accepted by the hash port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a pass when idle |
| cont_mode | input | 1 | 1 selects continuous compare mode; also keeps passes repeating |
| blk_en | input | NBLK | Per-block enable |
| seg_base | input | NBLK*NSEG*AW | Start address of each piece |
| seg_len | input | NBLK*NSEG*LW | Length of each piece in words |
| bus_on | input | TW | Cycles per window in which requests are allowed |
| bus_off | input | TW | Cycles per window in which requests are held back |
| wd_limit | input | WDW | Watchdog budget per block, in cycles |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_gnt | input | 1 | Request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | DW | Read data |
| hash_valid | output | 1 | Word offered to the hash engine |
| hash_data | output | DW | Word to hash |
| hash_last | output | 1 | Final word of a block's message |
| hash_ready | input | 1 | Hash engine takes the word |
| dig_valid | input | 1 | Digest of the current block is present |
| dig_data | input | DGW | Digest value |
| busy | output | 1 | A pass is in progress |
| done_irq | output | 1 | One-time pass finished (pulse) |
| mism_irq | output | 1 | Digest mismatch (pulse) |
| err_blk | output | $clog2(NBLK) | Block index of the latest mismatch |
| sec_err | output | 1 | Sticky error toward the security monitor |
| wd_timeout | output | 1 | Sticky watchdog expiry |

## Verification
The hardest case to reach is a continuous-mode compare that must fail for exactly one block, while showing that the failing digest did not overwrite the store. The stimulus first runs a one-time pass to fill the store, then a clean two-pass continuous run. Next it runs a continuous pass in which the digest driver corrupts block 3 only, followed by another clean continuous pass. That final pass must raise no new mismatch while `sec_err` stays high.

The watchdog expiry is reached by having the digest driver withhold its answer. The throttle limit is reached by delaying grants long enough that the request has to span several on/off windows.

// File: rtl/imc_pkg.sv
package imc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_REQ,
      ST_DATA,
      ST_FEED,
      ST_DIG,
      ST_HALT
   } seq_st_e;
endpackage

// File: rtl/imc_throttle.sv
module imc_throttle #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [TW-1:0] on_len,
   input  logic [TW-1:0] off_len,
   output logic          allow
);
   logic          off_ph_q;
   logic [TW-1:0] cnt_q;
   logic          limiting;

   assign limiting = (on_len != '0) && (off_len != '0);
   assign allow    = !off_ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_ph_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!active || !limiting) begin
         off_ph_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!off_ph_q) begin
         if (cnt_q == on_len - TW'(1)) begin
            off_ph_q <= 1'b1;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + TW'(1);
         end
      end else begin
         if (cnt_q == off_len - TW'(1)) begin
            off_ph_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + TW'(1);
         end
      end
   end
endmodule

// File: rtl/imc_watchdog.sv
module imc_watchdog #(
   parameter int WDW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reload,
   input  logic           run,
   input  logic [WDW-1:0] limit,
   output logic           expired
);
   logic [WDW-1:0] left_q;

   assign expired = run && !reload && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (reload)
         left_q <= limit;
      else if (run && left_q != '0)
         left_q <= left_q - WDW'(1);
   end
endmodule

// File: rtl/imc_seq.sv
module imc_seq
   import imc_pkg::*;
#(
   parameter int NBLK        = 4,
   parameter int NSEG        = 2,
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int LW          = 12,
   parameter int DGW         = 160,
   parameter int TW          = 8,
   parameter int WDW         = 16,
   parameter bit THROTTLE_EN = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic                                cont_mode,
   input  logic [NBLK-1:0]                     blk_en,
   input  logic [NBLK-1:0][NSEG-1:0][AW-1:0]   seg_base,
   input  logic [NBLK-1:0][NSEG-1:0][LW-1:0]   seg_len,
   input  logic [TW-1:0]                       bus_on,
   input  logic [TW-1:0]                       bus_off,
   input  logic [WDW-1:0]                      wd_limit,
   output logic                                rd_req,
   output logic [AW-1:0]                       rd_addr,
   input  logic                                rd_gnt,
   input  logic                                rd_rvalid,
   input  logic [DW-1:0]                       rd_rdata,
   output logic                                hash_valid,
   output logic [DW-1:0]                       hash_data,
   output logic                                hash_last,
   input  logic                                hash_ready,
   input  logic                                dig_valid,
   input  logic [DGW-1:0]                      dig_data,
   output logic                                busy,
   output logic                                done_irq,
   output logic                                mism_irq,
   output logic [$clog2(NBLK)-1:0]             err_blk,
   output logic                                sec_err,
   output logic                                wd_timeout
);
   localparam int BIX = $clog2(NBLK);
   localparam int BW  = $clog2(NBLK + 1);
   localparam int SIX = $clog2(NSEG);
   localparam logic [AW-1:0]  STEP    = AW'(DW / 8);
   localparam logic [BW-1:0]  BLK_END = BW'(NBLK);
   localparam logic [SIX-1:0] SEG_TOP = SIX'(NSEG - 1);

   if (NBLK < 2) begin : g_chk_nblk
      $error("imc_seq: NBLK must be at least 2");
   end
   if (NSEG < 2) begin : g_chk_nseg
      $error("imc_seq: NSEG must be at least 2");
   end
   if (DW % 8 != 0) begin : g_chk_dw
      $error("imc_seq: DW must be a whole number of bytes");
   end

   seq_st_e          st_q;
   logic [BW-1:0]    blk_q;
   logic [SIX-1:0]   seg_q;
   logic [AW-1:0]    addr_q;
   logic [LW-1:0]    cnt_q;
   logic [DW-1:0]    word_q;
   logic             mode_q;
   logic [DGW-1:0]   store_q [NBLK];

   logic [BIX-1:0]   blk_ix;
   logic [LW-1:0]    cur_len;
   logic [AW-1:0]    cur_base;
   logic             more_after;
   logic             word_is_last;
   logic             bus_allow;
   logic             wd_exp;
   logic             wd_run;
   logic             active;

   assign blk_ix   = blk_q[BIX-1:0];
   assign cur_len  = seg_len[blk_ix][seg_q];
   assign cur_base = seg_base[blk_ix][seg_q];

   // any non-empty piece later in the current block
   always_comb begin
      more_after = 1'b0;
      for (int s = 0; s < NSEG; s++) begin
         if (s > int'(seg_q) && seg_len[blk_ix][s] != '0)
            more_after = 1'b1;
      end
   end

   assign word_is_last = (cnt_q == LW'(1)) && !more_after;
   assign active       = (st_q != ST_IDLE) && (st_q != ST_HALT);
   assign wd_run       = (st_q == ST_REQ) || (st_q == ST_DATA) ||
                         (st_q == ST_FEED) || (st_q == ST_DIG);

   if (THROTTLE_EN) begin : g_thr
      imc_throttle #(.TW(TW)) u_thr (
         .clk     (clk),
         .rst_n   (rst_n),
         .active  (active),
         .on_len  (bus_on),
         .off_len (bus_off),
         .allow   (bus_allow)
      );
   end else begin : g_nothr
      assign bus_allow = 1'b1;
   end

   imc_watchdog #(.WDW(WDW)) u_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (st_q == ST_PICK && seg_q == '0),
      .run     (wd_run),
      .limit   (wd_limit),
      .expired (wd_exp)
   );

   assign rd_req     = (st_q == ST_REQ) && bus_allow;
   assign rd_addr    = addr_q;
   assign hash_valid = (st_q == ST_FEED);
   assign hash_data  = word_q;
   assign hash_last  = hash_valid && word_is_last;
   assign busy       = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         blk_q      <= '0;
         seg_q      <= '0;
         addr_q     <= '0;
         cnt_q      <= '0;
         word_q     <= '0;
         mode_q     <= 1'b0;
         done_irq   <= 1'b0;
         mism_irq   <= 1'b0;
         err_blk    <= '0;
         sec_err    <= 1'b0;
         wd_timeout <= 1'b0;
         for (int b = 0; b < NBLK; b++) store_q[b] <= '0;
      end else begin
         done_irq <= 1'b0;
         mism_irq <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               mode_q <= cont_mode;
               blk_q  <= '0;
               seg_q  <= '0;
               st_q   <= ST_PICK;
            end
            ST_PICK: begin
               if (blk_q == BLK_END) begin
                  blk_q <= '0;
                  seg_q <= '0;
                  if (!(mode_q && cont_mode)) begin
                     st_q     <= ST_IDLE;
                     done_irq <= !mode_q;
                  end
               end else if (blk_en[blk_ix] && cur_len != '0) begin
                  addr_q <= cur_base;
                  cnt_q  <= cur_len;
                  st_q   <= ST_REQ;
               end else if (blk_en[blk_ix] && seg_q != SEG_TOP) begin
                  seg_q <= seg_q + SIX'(1);
               end else begin
                  blk_q <= blk_q + BW'(1);
                  seg_q <= '0;
               end
            end
            ST_REQ: if (rd_req && rd_gnt) st_q <= ST_DATA;
            ST_DATA: if (rd_rvalid) begin
               word_q <= rd_rdata;
               st_q   <= ST_FEED;
            end
            ST_FEED: if (hash_ready) begin
               if (cnt_q != LW'(1)) begin
                  addr_q <= addr_q + STEP;
                  cnt_q  <= cnt_q - LW'(1);
                  st_q   <= ST_REQ;
               end else if (more_after) begin
                  seg_q <= seg_q + SIX'(1);
                  st_q  <= ST_PICK;
               end else begin
                  st_q <= ST_DIG;
               end
            end
            ST_DIG: if (dig_valid) begin
               if (!mode_q) begin
                  store_q[blk_ix] <= dig_data;
               end else if (dig_data != store_q[blk_ix]) begin
                  mism_irq <= 1'b1;
                  err_blk  <= blk_ix;
                  sec_err  <= 1'b1;
               end
               blk_q <= blk_q + BW'(1);
               seg_q <= '0;
               st_q  <= ST_PICK;
            end
            ST_HALT: st_q <= ST_HALT;
            default: st_q <= ST_IDLE;
         endcase
         if (wd_exp) begin
            st_q       <= ST_HALT;
            wd_timeout <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/imc_seq_chk.sv
module imc_seq_chk #(
   parameter int TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_req,
   input logic          rd_gnt,
   input logic          hash_valid,
   input logic          hash_last,
   input logic [TW-1:0] bus_on,
   input logic [TW-1:0] bus_off,
   input logic          done_irq,
   input logic          mism_irq,
   input logic          sec_err,
   input logic          wd_timeout
);
   logic [TW:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (!rd_req)
         run_q <= '0;
      else if (run_q != '1)
         run_q <= run_q + (TW+1)'(1);
   end

   // R8
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && bus_on != '0 && bus_off != '0) |-> (run_q < {1'b0, bus_on}));

   // R10
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_gnt) |=> !rd_req);

   // R4
   last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hash_last |-> hash_valid);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   // R7
   mism_raises_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mism_irq |=> sec_err);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_err |=> sec_err);

   // R9
   timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_timeout |=> wd_timeout);

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_timeout |-> (!rd_req && !hash_valid));
endmodule

bind imc_seq imc_seq_chk #(.TW(TW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_req     (rd_req),
   .rd_gnt     (rd_gnt),
   .hash_valid (hash_valid),
   .hash_last  (hash_last),
   .bus_on     (bus_on),
   .bus_off    (bus_off),
   .done_irq   (done_irq),
   .mism_irq   (mism_irq),
   .sec_err    (sec_err),
   .wd_timeout (wd_timeout)
);

// File: tb/imc_seq_bench.sv
`timescale 1ns/1ps
module imc_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                     start = 1'b0, cont_mode = 1'b0;
   logic [3:0]               blk_en = '0;
   logic [3:0][1:0][31:0]    seg_base = '0;
   logic [3:0][1:0][11:0]    seg_len = '0;
   logic [7:0]               bus_on = 8'd0, bus_off = 8'd0;
   logic [15:0]              wd_limit = 16'd4000;
   logic                     rd_req, rd_gnt = 1'b0, rd_rvalid = 1'b0;
   logic [31:0]              rd_addr, rd_rdata = '0;
   logic                     hash_valid, hash_last, hash_ready = 1'b0;
   logic [31:0]              hash_data;
   logic                     dig_valid = 1'b0;
   logic [159:0]             dig_data = '0;
   logic                     busy, done_irq, mism_irq, sec_err, wd_timeout;
   logic [1:0]               err_blk;

   imc_seq u_imc_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
      .blk_en(blk_en), .seg_base(seg_base), .seg_len(seg_len),
      .bus_on(bus_on), .bus_off(bus_off), .wd_limit(wd_limit),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
      .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
      .hash_valid(hash_valid), .hash_data(hash_data), .hash_last(hash_last),
      .hash_ready(hash_ready), .dig_valid(dig_valid), .dig_data(dig_data),
      .busy(busy), .done_irq(done_irq), .mism_irq(mism_irq),
      .err_blk(err_blk), .sec_err(sec_err), .wd_timeout(wd_timeout)
   );

   int checks = 0, errs = 0;
   logic [31:0] exp_data_q[$];
   bit          exp_last_q[$];
   int          exp_blk_q[$];
   int gnt_delay = 0, bad_blk = -1, salt = 1;
   bit withhold = 1'b0, track_run = 1'b0;
   int done_cnt = 0, mism_cnt = 0, served = 0, max_run = 0, seen_err_blk = -1;
   int run = 0, wcnt = 0, rctr = 0, dig_due = 0, cur_dblk = 0;
   bit pend = 1'b0, inflight = 1'b0;
   logic [31:0] paddr = '0;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
   endfunction

   function automatic logic [159:0] digest_for(input int b, input int s);
      return {32'hD1000000 + 32'(b), 32'(s), 32'(b * 7 + s),
              32'hC0DE0000 | 32'(b), 32'(s * 3 + b)};
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: expected word stream and digest-bearing blocks of one pass
   task automatic push_pass();
      for (int b = 0; b < 4; b++) begin
         if (blk_en[b]) begin
            int total = 0, k = 0;
            for (int s = 0; s < 2; s++) total += int'(seg_len[b][s]);
            for (int s = 0; s < 2; s++)
               for (int i = 0; i < int'(seg_len[b][s]); i++) begin
                  exp_data_q.push_back(mem_word(seg_base[b][s] + 32'(i * 4)));
                  exp_last_q.push_back(k == total - 1);
                  k++;
               end
            if (total != 0) exp_blk_q.push_back(b);
         end
      end
   endtask

   task automatic pulse_start(input bit cont, input bit drop_after);
      @(negedge clk);
      cont_mode = cont;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (drop_after) cont_mode = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // bus responder, hash sink, digest driver and scoreboard monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_gnt = 1'b0; rd_rvalid = 1'b0; pend = 1'b0; wcnt = 0;
         hash_ready = 1'b0; dig_valid = 1'b0; dig_due = 0; run = 0; inflight = 1'b0;
      end else begin
         if (done_irq) done_cnt++;
         if (mism_irq) begin mism_cnt++; seen_err_blk = int'(err_blk); end
         if (!track_run) begin run = 0; max_run = 0; end
         else if (rd_req) begin run++; if (run > max_run) max_run = run; end
         else run = 0;

         if (rd_req && inflight)
            chk(1'b0, "R10 request while a word is in flight", 1, 0);

         rd_rvalid = 1'b0;
         if (pend) begin rd_rvalid = 1'b1; rd_rdata = mem_word(paddr); pend = 1'b0; end
         rd_gnt = 1'b0;
         if (rd_req) begin
            if (wcnt >= gnt_delay) begin
               rd_gnt = 1'b1; pend = 1'b1; paddr = rd_addr; wcnt = 0; inflight = 1'b1;
            end else wcnt++;
         end

         dig_valid = 1'b0;
         if (dig_due != 0) begin
            dig_due--;
            if (dig_due == 0 && !withhold) begin
               dig_valid = 1'b1;
               dig_data  = digest_for(cur_dblk, salt) ^ ((cur_dblk == bad_blk) ? 160'd1 : 160'd0);
               served++;
            end
         end

         rctr++;
         hash_ready = (rctr % 3) != 2;
         if (hash_valid && hash_ready) begin
            inflight = 1'b0;
            if (exp_data_q.size() == 0) begin
               chk(1'b0, "R2 unexpected word", 64'(hash_data), 0);
            end else begin
               logic [31:0] ed;
               bit el;
               ed = exp_data_q.pop_front();
               el = exp_last_q.pop_front();
               chk(hash_data == ed, "R2 word value/order", 64'(hash_data), 64'(ed));
               chk(hash_last == el, "R4 last-word flag", 64'(hash_last), 64'(el));
            end
            if (hash_last) begin
               if (exp_blk_q.size() != 0) cur_dblk = exp_blk_q.pop_front();
               dig_due = 3;
            end
         end
      end
   end

   task automatic cfg_main();
      blk_en = 4'b1011;
      seg_base[0][0] = 32'h1000; seg_len[0][0] = 12'd4;
      seg_base[0][1] = 32'h3000; seg_len[0][1] = 12'd3;
      seg_base[1][0] = 32'h5000; seg_len[1][0] = 12'd0;
      seg_base[1][1] = 32'h5400; seg_len[1][1] = 12'd0;
      seg_base[2][0] = 32'h7000; seg_len[2][0] = 12'd2;
      seg_base[2][1] = 32'h7400; seg_len[2][1] = 12'd2;
      seg_base[3][0] = 32'h9000; seg_len[3][0] = 12'd0;
      seg_base[3][1] = 32'hB000; seg_len[3][1] = 12'd5;
   endtask

   bit finished = 1'b0;
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errs++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int d0, m0, s0, quiet;
      cfg_main();
      do_reset();
      // R1 reset state
      chk(rd_req == 0 && hash_valid == 0 && hash_last == 0, "R1 bus/hash idle", {rd_req, hash_valid}, 0);
      chk(busy == 0 && done_irq == 0 && mism_irq == 0, "R1 status idle", {busy, done_irq, mism_irq}, 0);
      chk(sec_err == 0 && wd_timeout == 0, "R1 sticky flags clear", {sec_err, wd_timeout}, 0);

      // one-time pass: stores digests
      d0 = done_cnt; m0 = mism_cnt; s0 = served;
      push_pass();
      pulse_start(1'b0, 1'b0);
      wait_idle();
      chk(exp_data_q.size() == 0, "R2 all words of the pass seen", exp_data_q.size(), 0);
      chk(served - s0 == 2, "R3 digests only for non-empty blocks", served - s0, 2);
      chk(done_cnt - d0 == 1, "R5 one done pulse", done_cnt - d0, 1);
      chk(mism_cnt == m0, "R5 no compare in one-time mode", mism_cnt - m0, 0);

      // continuous, two clean passes
      d0 = done_cnt; s0 = served;
      push_pass(); push_pass();
      pulse_start(1'b1, 1'b0);
      while (served < s0 + 3) @(negedge clk);
      cont_mode = 1'b0;
      wait_idle();
      chk(exp_data_q.size() == 0 && served - s0 == 4, "R6 exactly two passes", served - s0, 4);
      chk(mism_cnt == m0 && sec_err == 0, "R6 stored digests match", mism_cnt - m0, 0);
      chk(done_cnt == d0, "R6 no done pulse in continuous mode", done_cnt - d0, 0);

      // continuous pass with block 3 corrupted
      bad_blk = 3;
      push_pass();
      pulse_start(1'b1, 1'b1);
      wait_idle();
      chk(mism_cnt - m0 == 1, "R7 one mismatch pulse", mism_cnt - m0, 1);
      chk(seen_err_blk == 3, "R7 failing block index", seen_err_blk, 3);
      chk(sec_err == 1, "R7 error line set", sec_err, 1);

      // clean continuous pass: store was not overwritten
      bad_blk = -1;
      push_pass();
      pulse_start(1'b1, 1'b1);
      wait_idle();
      chk(mism_cnt - m0 == 1, "R6 failing digest not stored", mism_cnt - m0, 1);
      chk(sec_err == 1, "R7 error line sticky", sec_err, 1);
      chk(wd_timeout == 0, "R9 no expiry with ample budget", wd_timeout, 0);

      // throttle
      do_reset();
      bus_on = 8'd3; bus_off = 8'd4; gnt_delay = 12; track_run = 1'b1;
      push_pass();
      pulse_start(1'b0, 1'b0);
      wait_idle();
      chk(max_run == 3, "R8 longest request burst equals on window", max_run, 3);
      chk(exp_data_q.size() == 0, "R8 pass completes under throttle", exp_data_q.size(), 0);
      track_run = 1'b0; bus_on = 8'd0; bus_off = 8'd0; gnt_delay = 0;

      // watchdog
      do_reset();
      wd_limit = 16'd60; withhold = 1'b1;
      d0 = done_cnt;
      push_pass();
      pulse_start(1'b0, 1'b0);
      repeat (300) @(negedge clk);
      chk(wd_timeout == 1, "R9 timeout flagged", wd_timeout, 1);
      chk(exp_data_q.size() == 5, "R9 sequencer stopped after block 0", exp_data_q.size(), 5);
      chk(busy == 0, "R9 not busy after halt", busy, 0);
      quiet = 0;
      pulse_start(1'b0, 1'b0);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rd_req || hash_valid) quiet++;
      end
      chk(quiet == 0, "R9 no activity after halt despite start", quiet, 0);
      chk(wd_timeout == 1 && done_cnt == d0, "R9 timeout sticky, no done", {wd_timeout, 1'b0}, 2);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule